// File: doc/BRIEF.md
# DMA Channel Sequencer and Status Register

This block holds the control and status state for a single DMA channel. A transfer trigger starts a transaction. The transaction moves a block of `blk_size_i` bytes as a series of bursts. The channel asks for one byte per cycle through a request/acknowledge pair, and a byte is counted in every cycle where both `req_o` and `ack_i` are high. The block does not generate addresses, arbitrate the bus or move data. Those functions sit around it.

Software reaches the block through a byte-wide register port. Select 0 is the control register:

- bit 2: single-shot enable.
- bits 1:0: burst length code.

Select 1 is the status register:

- bit 7: busy flag.
- bit 6: pending flag.
- bit 5: error flag.
- bit 4: complete flag.
- bits 3:2: error interrupt level.
- bits 1:0: complete interrupt level.

The error and complete flags drive one shared interrupt line. That interrupt carries a two-bit priority level. Software clears each flag on its own, by writing a one to that flag's bit.

Top module: `dma_chan_ctrl`

## Requirements
- R1: The burst length code sets the burst size: 00 gives 1 byte, 01 gives 2, 10 gives 4 and 11 gives 8. If fewer bytes remain in the block, the burst is cut short to the remaining count.
- R2: In single-shot mode (control bit 2 = 1), each trigger runs exactly one burst. The channel then waits with busy = 1 and `req_o` = 0 until the next trigger runs the next burst.
- R3: A write to the control register (select 0) while busy = 1 has no effect on its contents.
- R4: In normal mode, one trigger moves all `blk_size_i` bytes (at least 1) as back-to-back bursts, and `req_o` stays high until the last byte.
- R5: When the last byte of a block is taken without repeat, status bit 4 (complete) sets and busy clears on the same clock edge.
- R6: With `repeat_i` high, the complete flag sets after every block. Busy stays at one and the next block starts without a new trigger.
- R7: While the channel is enabled, `err_i` sets status bit 5 (error). It also aborts the channel: at the next edge busy, pending and `req_o` are all 0.
- R8: A status write clears bit 5 or bit 4 only where the written data has a one. A zero in those positions leaves the flag unchanged. A set event in the same cycle wins over the clear. The write always loads bits 3:2 and 1:0.
- R9: A trigger that arrives while bytes are moving sets status bit 6 (pending). After that transaction completes, the channel is idle for one cycle. It then restarts by itself and clears pending.
- R10: While `enable_i` is low, busy and pending are 0 and triggers are ignored.
- R11: `irq_lvl_o` equals the highest level among the flags that are set. A level of 00 masks its source.
- R12: After reset, both registers read 0, and `req_o` and `irq_lvl_o` are 0.
- R13: At most one byte is counted per cycle, and only when `req_o` and `ack_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable; low aborts the channel |
| trig_i | input | 1 | Transfer trigger |
| repeat_i | input | 1 | Unlimited repeat of the block |
| blk_size_i | input | CNT_W | Block length in bytes (at least 1) |
| err_i | input | 1 | Error condition detected |
| ack_i | input | 1 | Byte accepted |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| req_o | output | 1 | Byte transfer request |
| irq_lvl_o | output | 2 | Shared interrupt level, 0 means no request |

## Verification
The assertions assume three things about the inputs:

- `blk_size_i` is never zero.
- `blk_size_i` and `repeat_i` only change while the channel is idle or disabled.
- `err_i` is a single-cycle pulse.

The stimulus respects all three. It draws block sizes from 1 upward. It changes block size and repeat setting only after a completion or a disable. It raises the error input for one cycle at a time.

Acknowledge stalls and interrupt levels are drawn at random from a fixed seed. Directed cases cover four situations:

- a truncated final burst;
- a write attempted during busy;
- a trigger that becomes pending;
- the repeat boundary.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_WAIT} chan_st_e;

  localparam int BIT_BUSY = 7;
  localparam int BIT_PEND = 6;
  localparam int BIT_ERRF = 5;
  localparam int BIT_DONF = 4;
  localparam int BIT_SNGL = 2;
  localparam int BST_W    = 4;

  function automatic logic [BST_W-1:0] burst_bytes(input logic [1:0] code);
    return BST_W'(1) << code;
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  input  logic       busy_i,
  input  logic       pend_i,
  input  logic       set_err_i,
  input  logic       set_done_i,
  output logic [7:0] rdata_o,
  output logic       single_o,
  output logic [1:0] blen_o,
  output logic       err_flag_o,
  output logic       done_flag_o,
  output logic [1:0] err_lvl_o,
  output logic [1:0] done_lvl_o
);
  logic stat_we, ctrl_we;
  assign stat_we = we_i & sel_i;
  assign ctrl_we = we_i & ~sel_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_o    <= 1'b0;
      blen_o      <= 2'b00;
      err_flag_o  <= 1'b0;
      done_flag_o <= 1'b0;
      err_lvl_o   <= 2'b00;
      done_lvl_o  <= 2'b00;
    end else begin
      if (ctrl_we) begin
        single_o <= wdata_i[BIT_SNGL];
        blen_o   <= wdata_i[1:0];
      end
      if (stat_we) begin
        err_lvl_o  <= wdata_i[3:2];
        done_lvl_o <= wdata_i[1:0];
      end
      // set beats write-one-to-clear
      err_flag_o  <= set_err_i  | (err_flag_o  & ~(stat_we & wdata_i[BIT_ERRF]));
      done_flag_o <= set_done_i | (done_flag_o & ~(stat_we & wdata_i[BIT_DONF]));
    end
  end

  always_comb begin
    if (sel_i) rdata_o = {busy_i, pend_i, err_flag_o, done_flag_o, err_lvl_o, done_lvl_o};
    else       rdata_o = {5'b00000, single_o, blen_o};
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             trig_i,
  input  logic             err_i,
  input  logic             ack_i,
  input  logic             single_i,
  input  logic [1:0]       blen_i,
  input  logic             repeat_i,
  input  logic [CNT_W-1:0] blk_size_i,
  output logic             busy_o,
  output logic             pend_o,
  output logic             req_o,
  output logic             set_done_o
);
  chan_st_e         st_q;
  logic [CNT_W-1:0] blk_left_q;
  logic [BST_W-1:0] bst_left_q;
  logic [BST_W-1:0] bst_sz;
  logic             byte_ok, blk_end, bst_end, abort;

  function automatic logic [BST_W-1:0] clip(input logic [CNT_W-1:0] n,
                                            input logic [BST_W-1:0] sz);
    if (n < CNT_W'(sz)) return n[BST_W-1:0];
    return sz;
  endfunction

  assign bst_sz     = burst_bytes(blen_i);
  assign abort      = ~enable_i | err_i;
  assign byte_ok    = (st_q == ST_XFER) & ack_i;
  assign blk_end    = byte_ok & (blk_left_q == CNT_W'(1));
  assign bst_end    = byte_ok & (bst_left_q == BST_W'(1));
  assign set_done_o = blk_end & ~abort;
  assign busy_o     = (st_q != ST_IDLE);
  assign req_o      = (st_q == ST_XFER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      pend_o     <= 1'b0;
      blk_left_q <= '0;
      bst_left_q <= '0;
    end else if (abort) begin
      st_q   <= ST_IDLE;
      pend_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (trig_i || pend_o) begin
          st_q       <= ST_XFER;
          pend_o     <= 1'b0;
          blk_left_q <= blk_size_i;
          bst_left_q <= clip(blk_size_i, bst_sz);
        end
        ST_XFER: begin
          if (trig_i) pend_o <= 1'b1;
          if (byte_ok) begin
            blk_left_q <= blk_left_q - CNT_W'(1);
            bst_left_q <= bst_left_q - BST_W'(1);
            if (blk_end) begin
              if (repeat_i) begin
                blk_left_q <= blk_size_i;
                bst_left_q <= clip(blk_size_i, bst_sz);
                if (single_i) st_q <= ST_WAIT;
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (bst_end) begin
              if (single_i) st_q <= ST_WAIT;
              else bst_left_q <= clip(blk_left_q - CNT_W'(1), bst_sz);
            end
          end
        end
        ST_WAIT: if (trig_i) begin
          st_q       <= ST_XFER;
          bst_left_q <= clip(blk_left_q, bst_sz);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq (
  input  logic       err_flag_i,
  input  logic       done_flag_i,
  input  logic [1:0] err_lvl_i,
  input  logic [1:0] done_lvl_i,
  output logic [1:0] lvl_o
);
  logic [1:0] e_lvl, d_lvl;
  assign e_lvl = err_flag_i  ? err_lvl_i  : 2'b00;
  assign d_lvl = done_flag_i ? done_lvl_i : 2'b00;
  assign lvl_o = (e_lvl > d_lvl) ? e_lvl : d_lvl;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             trig_i,
  input  logic             repeat_i,
  input  logic [CNT_W-1:0] blk_size_i,
  input  logic             err_i,
  input  logic             ack_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             req_o,
  output logic [1:0]       irq_lvl_o
);
  logic       busy, pend, set_done, set_err;
  logic       single, err_flag, done_flag;
  logic [1:0] blen, err_lvl, done_lvl;

  assign set_err = err_i & enable_i;

  dma_chan_regs u_regs (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy),
    .pend_i      (pend),
    .set_err_i   (set_err),
    .set_done_i  (set_done),
    .rdata_o     (reg_rdata_o),
    .single_o    (single),
    .blen_o      (blen),
    .err_flag_o  (err_flag),
    .done_flag_o (done_flag),
    .err_lvl_o   (err_lvl),
    .done_lvl_o  (done_lvl)
  );

  dma_chan_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .enable_i, .trig_i, .err_i, .ack_i,
    .single_i   (single),
    .blen_i     (blen),
    .repeat_i,
    .blk_size_i,
    .busy_o     (busy),
    .pend_o     (pend),
    .req_o,
    .set_done_o (set_done)
  );

  dma_chan_irq u_irq (
    .err_flag_i  (err_flag),
    .done_flag_i (done_flag),
    .err_lvl_i   (err_lvl),
    .done_lvl_i  (done_lvl),
    .lvl_o       (irq_lvl_o)
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       err_i,
  input logic       reg_we_i,
  input logic       reg_sel_i,
  input logic [7:0] reg_wdata_i,
  input logic       req_o,
  input logic [1:0] irq_lvl_o,
  input logic       busy,
  input logic       pend,
  input logic       err_flag,
  input logic       done_flag,
  input logic [2:0] ctrl_q
);
  a_r3_ctrl_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i && !reg_sel_i) |=> $stable(ctrl_q));

  a_r5_busy_drop_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (done_flag || $past(err_i) || !$past(enable_i)));

  a_r7_err_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && enable_i) |=> (!busy && !pend && !req_o && err_flag));

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_flag) |-> $past(reg_we_i && reg_sel_i && reg_wdata_i[4]));

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_flag) |-> $past(reg_we_i && reg_sel_i && reg_wdata_i[5]));

  a_r10_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!busy && !pend));

  a_r11_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lvl_o != 2'b00) |-> (err_flag || done_flag));

  a_r13_req_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy);
endmodule

bind dma_chan_ctrl dma_chan_chk u_chk (
  .clk_i, .rst_ni, .enable_i, .err_i, .reg_we_i, .reg_sel_i, .reg_wdata_i,
  .req_o, .irq_lvl_o,
  .busy      (busy),
  .pend      (pend),
  .err_flag  (err_flag),
  .done_flag (done_flag),
  .ctrl_q    ({single, blen})
);

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enable_i = 1'b0, trig_i = 1'b0, repeat_i = 1'b0;
  logic [CNT_W-1:0] blk_size_i = '0;
  logic             err_i = 1'b0, ack_i = 1'b0;
  logic             reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0]       reg_wdata_i = '0;
  logic [7:0]       reg_rdata_o;
  logic             req_o;
  logic [1:0]       irq_lvl_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] v;
  int n;

  always #2 clk_i = ~clk_i;

  dma_chan_ctrl #(.CNT_W(CNT_W)) u0 (.*);

  function automatic int max_lvl(input bit ef, input bit df, input int el, input int dl);
    int a, b;
    a = ef ? el : 0;
    b = df ? dl : 0;
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = s; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    reg_sel_i = s;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic trig();
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
  endtask

  task automatic kill();
    @(negedge clk_i); enable_i = 1'b0;
    @(negedge clk_i); enable_i = 1'b1;
  endtask

  // random-stall acknowledge; counts bytes taken until req drops
  task automatic pump(output int cnt);
    cnt = 0;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk_i);
      if (!req_o) begin ack_i = 1'b0; break; end
      ack_i = ($urandom % 4) != 0;
      if (ack_i) cnt++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n = $urandom(32'd4242);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    rd(0, v); chk("R12 ctrl", v, 0);
    rd(1, v); chk("R12 status", v, 0);
    chk("R12 req", req_o, 0);
    chk("R12 irq", irq_lvl_o, 0);

    enable_i = 1'b1; blk_size_i = 200;
    // R1 burst decode, R2 single-shot wait
    for (int b = 0; b < 4; b++) begin
      wr(0, 8'(4 + b));
      trig(); pump(n);
      chk("R1 burst bytes", n, 1 << b);
      rd(1, v); chk("R2 busy after burst", v[7], 1);
      chk("R2 req after burst", req_o, 0);
      kill();
    end
    wr(0, 8'h05);
    trig(); pump(n); chk("R2 first burst", n, 2);
    trig(); pump(n); chk("R2 second burst", n, 2);
    // R3 lock while busy
    wr(0, 8'h03);
    rd(0, v); chk("R3 ctrl locked", v, 8'h05);
    // R10 disable
    @(negedge clk_i); enable_i = 1'b0;
    @(negedge clk_i);
    rd(1, v); chk("R10 busy off", v[7], 0);
    trig();
    rd(1, v); chk("R10 trigger ignored", v[7:6], 0);
    enable_i = 1'b1;

    // R1 truncated last burst, R5 completion
    blk_size_i = 5;
    wr(0, 8'h06);
    trig(); pump(n); chk("R1 full burst", n, 4);
    trig(); pump(n); chk("R1 truncated burst", n, 1);
    rd(1, v); chk("R5 busy clear", v[7], 0); chk("R5 done set", v[4], 1);
    // R8 write-one-to-clear
    wr(1, 8'h00); rd(1, v); chk("R8 zero keeps", v[4], 1);
    wr(1, 8'h10); rd(1, v); chk("R8 one clears", v[4], 0);

    // R4 whole block, R13 byte counting
    for (int i = 0; i < 6; i++) begin
      blk_size_i = CNT_W'(1 + $urandom % 40);
      wr(0, 8'($urandom % 4));
      trig(); pump(n);
      chk("R4 block bytes", n, int'(blk_size_i));
      rd(1, v); chk("R5 done after block", v[7:4], 4'b0001);
      wr(1, 8'h10);
    end

    // R9 pending trigger
    blk_size_i = 6; wr(0, 8'h00);
    trig(); trig();
    rd(1, v); chk("R9 pend set", v[6], 1);
    pump(n); chk("R9 first block", n, 6);
    rd(1, v); chk("R9 idle gap", v[7:6], 2'b01);
    @(negedge clk_i);
    rd(1, v); chk("R9 restart", v[7:6], 2'b10);
    pump(n); chk("R9 second block", n, 6);
    wr(1, 8'h10);

    // R6 repeat
    repeat_i = 1'b1; blk_size_i = 4; wr(0, 8'h01);
    trig();
    @(negedge clk_i); ack_i = 1'b1;
    repeat (4) @(negedge clk_i);
    ack_i = 1'b0;
    rd(1, v); chk("R6 done per block", v[4], 1); chk("R6 still busy", v[7], 1);
    chk("R6 req continues", req_o, 1);
    kill(); repeat_i = 1'b0; wr(1, 8'h10);

    // R7 error abort
    blk_size_i = 20;
    trig();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0; err_i = 1'b1;
    @(negedge clk_i); err_i = 1'b0;
    rd(1, v); chk("R7 err flag", v[5], 1); chk("R7 busy", v[7], 0);
    chk("R7 req", req_o, 0);

    // R11 interrupt level
    blk_size_i = 1;
    trig(); pump(n);
    for (int i = 0; i < 16; i++) begin
      automatic int el = $urandom % 4;
      automatic int dl = $urandom % 4;
      wr(1, 8'(el * 4 + dl));
      #1 chk("R11 irq both", irq_lvl_o, max_lvl(1, 1, el, dl));
    end
    wr(1, 8'h23);
    #1 chk("R11 irq done only", irq_lvl_o, max_lvl(0, 1, 0, 3));
    wr(1, 8'h10);
    #1 chk("R11 irq none", irq_lvl_o, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule